// File: doc/BRIEF.md
# Double-Press Dimmable Lamp Controller

This block drives a lamp with three light levels (off, low and bright) from a single push-button. The button arrives as a one-clock pulse that has already been debounced and synchronized, and a separate tick pulse gives the time base. The first press turns the lamp on at the low level and starts an elapsed-time counter from zero. A second press that comes soon enough raises the lamp to bright. A second press that comes too late turns the lamp off. From bright, any press turns the lamp off.

The elapsed-time counter advances once per tick and stops at its maximum value, so a very long wait cannot wrap around and look like a short one. The level is presented as a registered two-bit code, together with one enable line for each lit level, which the power stage uses to drive the lamp.

Top module: `dimlamp_ctrl`

## Requirements
- R1: While reset is asserted and after it is released, with no press, the level code is 00 (off) and both enables are low.
- R2: A press while off makes the level code 01 (low) on the next clock edge.
- R3: A press while low, with fewer than WINDOW ticks (default 5) counted since the press that lit the lamp, makes the level code 10 (bright) on the next edge.
- R4: A press while low, with WINDOW or more ticks counted since the lighting press, makes the level code 00 (off) on the next edge.
- R5: A press while bright makes the level code 00 on the next edge, whatever number of ticks has passed.
- R6: Every press that lights the lamp from off restarts the tick count at zero, even when ticks counted earlier have left it high.
- R7: The tick count saturates at 2^CNT_W-1 (15 by default) and does not wrap, so a long wait followed by a press while low always turns the lamp off.
- R8: When a press and a tick arrive in the same cycle, the press is judged against the count before that tick is added.
- R9: low_en is 1 exactly when the level code is 01, and bright_en is 1 exactly when it is 10. They are never high together.
- R10: Without a press the level does not change, however many ticks arrive.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset; release is synchronized inside the block |
| press_i | input | 1 | One-cycle button press pulse |
| tick_i | input | 1 | One-cycle time-base pulse |
| level_o | output | 2 | Registered level code: 00 off, 01 low, 10 bright |
| low_en_o | output | 1 | High while the level is low |
| bright_en_o | output | 1 | High while the level is bright |

## Verification
A wrong level state appears on level_o and the enables on the edge right after the press that caused it, so each level check is made one cycle after its stimulus. A wrong tick count cannot be seen directly. It appears only when the next press in the low state picks bright instead of off, or off instead of bright. The tests therefore place presses on both sides of the window boundary: at counts 4 and 5, after the count has saturated, after the count has been restarted, and with a tick in the same cycle as the press. An off-by-one error, a count that wraps, or a count that was not cleared will then change the outcome of a single press.

// File: rtl/lamp_pkg.sv
package lamp_pkg;
  typedef enum logic [1:0] {
    LVL_OFF    = 2'b00,
    LVL_LOW    = 2'b01,
    LVL_BRIGHT = 2'b10
  } lvl_e;
endpackage

// File: rtl/lamp_elapsed.sv
module lamp_elapsed #(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear_i,
  input  logic             tick_i,
  output logic [CNT_W-1:0] count_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;
  logic             at_max;

  assign at_max = (cnt_q == CNT_MAX);

  always_comb begin
    cnt_d  = cnt_q;
    cnt_en = 1'b0;
    if (clear_i) begin
      cnt_d  = '0;
      cnt_en = 1'b1;
    end else if (tick_i && !at_max) begin
      cnt_d  = cnt_q + 1'b1;
      cnt_en = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign count_o = cnt_q;

  // R6: a clear request leaves the count at zero
  p_clear_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
    clear_i |=> (count_o == '0));

  // R6: a tick below the ceiling advances by exactly one
  p_tick_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_i && !clear_i && count_o != CNT_MAX) |=> (count_o == $past(count_o) + 1'b1));

  // R7: at the ceiling the count holds
  p_sat_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (count_o == CNT_MAX && !clear_i) |=> (count_o == CNT_MAX));
endmodule

// File: rtl/lamp_fsm.sv
module lamp_fsm
  import lamp_pkg::*;
#(
  parameter int CNT_W  = 4,
  parameter int WINDOW = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             press_i,
  input  logic [CNT_W-1:0] count_i,
  output lvl_e             state_o,
  output logic             clear_o
);
  localparam logic [CNT_W-1:0] WIN_LIM = CNT_W'(WINDOW);

  lvl_e state_q, state_d;
  logic in_window;

  assign in_window = (count_i < WIN_LIM);

  always_comb begin
    state_d = state_q;
    if (press_i) begin
      unique case (state_q)
        LVL_OFF:    state_d = LVL_LOW;
        LVL_LOW:    state_d = in_window ? LVL_BRIGHT : LVL_OFF;
        LVL_BRIGHT: state_d = LVL_OFF;
        default:    state_d = LVL_OFF;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       state_q <= LVL_OFF;
    else if (press_i) state_q <= state_d;
  end

  assign clear_o = press_i && (state_q == LVL_OFF);
  assign state_o = state_q;

  // R2
  p_off_to_low_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (press_i && state_o == LVL_OFF) |=> (state_o == LVL_LOW));

  // R3
  p_fast_bright_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (press_i && state_o == LVL_LOW && count_i < WIN_LIM) |=> (state_o == LVL_BRIGHT));

  // R4
  p_slow_off_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (press_i && state_o == LVL_LOW && count_i >= WIN_LIM) |=> (state_o == LVL_OFF));

  // R5
  p_bright_off_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (press_i && state_o == LVL_BRIGHT) |=> (state_o == LVL_OFF));

  // R10
  p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !press_i |=> $stable(state_o));
endmodule

// File: rtl/lamp_decode.sv
module lamp_decode
  import lamp_pkg::*;
(
  input  lvl_e        state_i,
  output logic [1:0]  level_o,
  output logic        low_en_o,
  output logic        bright_en_o
);
  always_comb begin
    level_o     = state_i;
    low_en_o    = (state_i == LVL_LOW);
    bright_en_o = (state_i == LVL_BRIGHT);
  end

  // R9
  always_comb begin
    p_enables_excl_r9: assert (!(low_en_o && bright_en_o));
  end
endmodule

// File: rtl/dimlamp_ctrl.sv
module dimlamp_ctrl
  import lamp_pkg::*;
#(
  parameter int CNT_W  = 4,
  parameter int WINDOW = 5
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       press_i,
  input  logic       tick_i,
  output logic [1:0] level_o,
  output logic       low_en_o,
  output logic       bright_en_o
);
  localparam int SYNC_STAGES = 2;

  logic [SYNC_STAGES-1:0] rst_sync_q;
  logic                   rst_int_n;
  logic [CNT_W-1:0]       count;
  logic                   clear;
  lvl_e                   state;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= '0;
    else        rst_sync_q <= {rst_sync_q[SYNC_STAGES-2:0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[SYNC_STAGES-1];

  lamp_elapsed #(.CNT_W(CNT_W)) u_elapsed (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .clear_i (clear),
    .tick_i  (tick_i),
    .count_o (count)
  );

  lamp_fsm #(.CNT_W(CNT_W), .WINDOW(WINDOW)) u_fsm (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .press_i (press_i),
    .count_i (count),
    .state_o (state),
    .clear_o (clear)
  );

  lamp_decode u_decode (
    .state_i     (state),
    .level_o     (level_o),
    .low_en_o    (low_en_o),
    .bright_en_o (bright_en_o)
  );

  // R1
  p_reset_off_r1: assert property (@(posedge clk)
    !rst_int_n |=> (level_o == 2'b00 || !rst_int_n));
endmodule

// File: tb/dimlamp_ctrl_tb.sv
module dimlamp_ctrl_tb;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       press_i;
  logic       tick_i;
  logic [1:0] level_o;
  logic       low_en_o;
  logic       bright_en_o;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  always #5 clk = ~clk;

  dimlamp_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .press_i(press_i), .tick_i(tick_i),
    .level_o(level_o), .low_en_o(low_en_o), .bright_en_o(bright_en_o)
  );

  task automatic chk(input string req, input logic [1:0] exp_lvl);
    logic [3:0] act, exp;
    act = {level_o, low_en_o, bright_en_o};
    exp = {exp_lvl, exp_lvl == 2'b01, exp_lvl == 2'b10};
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: {level,low_en,bright_en} actual=%b expected=%b", req, act, exp);
    end
  endtask

  // one cycle of stimulus, driven at the falling edge, result seen at the next falling edge
  task automatic step(input logic p, input logic t);
    @(negedge clk);
    press_i = p;
    tick_i  = t;
    @(negedge clk);
    press_i = 1'b0;
    tick_i  = 1'b0;
  endtask

  task automatic do_press();  step(1'b1, 1'b0); endtask
  task automatic do_ticks(input int n);
    for (int i = 0; i < n; i++) step(1'b0, 1'b1);
  endtask

  task automatic go_off();
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  task automatic t_reset();
    press_i = 1'b0; tick_i = 1'b0; rst_n = 1'b0;
    repeat (3) @(negedge clk);
    chk("R1 during reset", 2'b00);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk("R1 after release", 2'b00);
  endtask

  task automatic t_first_press();
    go_off();
    do_press();
    chk("R2 off->low / R9 low_en", 2'b01);
  endtask

  task automatic t_fast_double();
    go_off();
    do_press();
    do_press();
    chk("R3 immediate second press / R9 bright_en", 2'b10);
    go_off();
    do_press(); do_ticks(4); do_press();
    chk("R3 second press at count 4", 2'b10);
  endtask

  task automatic t_slow_double();
    go_off();
    do_press(); do_ticks(5); do_press();
    chk("R4 second press at count 5", 2'b00);
    go_off();
    do_press(); do_ticks(9); do_press();
    chk("R4 second press at count 9", 2'b00);
  endtask

  task automatic t_bright_off();
    go_off();
    do_press(); do_press(); do_ticks(12);
    chk("R10 bright holds over ticks", 2'b10);
    do_press();
    chk("R5 bright->off after long wait", 2'b00);
    do_press(); do_press(); do_press();
    chk("R5 bright->off immediately", 2'b00);
  endtask

  task automatic t_restart();
    go_off();
    do_press(); do_ticks(3); do_press(); do_press();
    chk("R6 setup back to off", 2'b00);
    do_press(); do_ticks(4); do_press();
    chk("R6 count restarted on relight", 2'b10);
    go_off();
    do_ticks(9);
    do_press(); do_press();
    chk("R6 ticks counted while off discarded", 2'b10);
  endtask

  task automatic t_saturation();
    go_off();
    do_press(); do_ticks(20);
    chk("R10 low holds over ticks", 2'b01);
    do_press();
    chk("R7 no wrap after 20 ticks", 2'b00);
    go_off();
    do_press(); do_ticks(16); do_press();
    chk("R7 no wrap after 16 ticks", 2'b00);
  endtask

  task automatic t_same_cycle();
    go_off();
    do_press(); do_ticks(4); step(1'b1, 1'b1);
    chk("R8 press with tick at count 4", 2'b10);
    go_off();
    do_press(); do_ticks(5); step(1'b1, 1'b1);
    chk("R8 press with tick at count 5", 2'b00);
    go_off();
    step(1'b1, 1'b1); do_ticks(4); do_press();
    chk("R8 relight with tick clears count", 2'b10);
  endtask

  task automatic t_hold_off();
    go_off();
    do_ticks(7);
    chk("R10 off holds over ticks", 2'b00);
  endtask

  initial begin
    #1000000;
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_first_press();
    t_fast_double();
    t_slow_double();
    t_bright_off();
    t_restart();
    t_saturation();
    t_same_cycle();
    t_hold_off();
    done = 1'b1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule